// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock peripheral on a simple 32-bit register bus. The bus clock drives every register. An external pulse, one bus-clock cycle wide, marks each elapsed second. The block counts seconds, minutes, hours, day of month, month and a two-digit year in packed BCD. The year runs from 2000 to 2099. A binary weekday counter steps with the day. A full date-and-time alarm compares against the running count. Two interrupt sources, alarm and per-second update, are gated by an enable register. They are held in a status register that software clears by writing ones, and they are combined onto one interrupt line.

After reset the clock is locked. Software must write a fixed 32-bit key to the activation register. Until it does, second pulses are ignored and writes to the time, calendar, weekday and alarm registers have no effect. Software polls bit 0 of that register, rewriting the key until the bit reads 1.

Reads are registered: the read-data port shows the addressed register one clock after the address is presented. The time or calendar may change between two reads, so a reader compares a second read against the first and retries on a mismatch.

Top module: `bcd_rtc`

## Requirements
- R1: After reset these values hold: activation bit 0 reads 0, time reads 0x000000, calendar reads 0x000101 (year 00, month 01, day 01), weekday reads 0, status reads 0, and the interrupt output is 0.
- R2: Writing 0xA5EB1357 to offset 0x00 sets bit 0 of that register, and the bit stays set until reset. Writing any other value there leaves it clear.
- R3: While the block is not activated, second pulses change nothing, and writes to time (0x0C), calendar (0x10), weekday (0x18), alarm time (0x1C) and alarm calendar (0x20) are ignored.
- R4: Time packs BCD seconds in [7:0], minutes in [15:8] and hours in [23:16]. Calendar packs BCD day in [7:0], month in [15:8] and year in [23:16]. The alarm registers use the same layouts. A read returns the register selected by the address one clock earlier.
- R5: Each accepted pulse advances the seconds. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00.
- R6: The day wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 otherwise. On each day carry the weekday steps by one, going from 6 back to 0.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00. Bit 0 at offset 0x24 reads 1 when the current year is a multiple of 4.
- R8: Status bit 0 (the alarm flag) sets on the pulse after which all six time and calendar fields equal the alarm registers.
- R9: Status bit 1 (the update flag) sets on every accepted pulse.
- R10: Writing 1 to a status bit at offset 0x2C clears it, and writing 0 leaves it as it is. If a flag sets in the same cycle as its clear, the flag stays set.
- R11: The interrupt output is the registered OR of each status bit ANDed with its enable bit at offset 0x28 (bit 0 for alarm, bit 1 for update).
- R12: A software write to time, calendar or weekday in the same cycle as an accepted pulse loads the written value in place of the advanced one.
- R13: The clock-format register at offset 0x14 always reads 1 in bit 0 (24-hour counting), and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse marking a second |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the per-second update and a software write-one-to-clear of the status register. The bench raises a pulse and then issues the clear in exactly the cycle in which the counter reports the advance. Reading status back must show the update flag still set, and a later clear alone must empty it.

The second pair is a pulse and a software time write arriving on the same edge. There the written time must read back unchanged, not one second later, while the update flag still sets.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
  } date_t;

  localparam int OFS_INIT  = 'h00;
  localparam int OFS_TIME  = 'h0C;
  localparam int OFS_CAL   = 'h10;
  localparam int OFS_FMT   = 'h14;
  localparam int OFS_WDAY  = 'h18;
  localparam int OFS_ATIME = 'h1C;
  localparam int OFS_ACAL  = 'h20;
  localparam int OFS_LEAP  = 'h24;
  localparam int OFS_IEN   = 'h28;
  localparam int OFS_STS   = 'h2C;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_bcd(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import bcd_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        active_i,
  input  logic        tick_i,
  input  logic        wr_tod_i,
  input  logic        wr_date_i,
  input  logic        wr_wday_i,
  input  logic [23:0] wdata_i,
  output tod_t        tod_o,
  output date_t       date_o,
  output logic [2:0]  wday_o,
  output logic        stepped_o
);

  logic  adv;
  tod_t  tod_q, tod_n;
  date_t date_q, date_n;
  logic [2:0] wday_q, wday_n;
  logic  c_min, c_hr, c_day, c_mon, c_yr;

  assign adv = tick_i && active_i;

  always_comb begin
    c_min = (tod_q.sec >= 8'h59);
    c_hr  = c_min && (tod_q.min >= 8'h59);
    c_day = c_hr  && (tod_q.hr  >= 8'h23);
    c_mon = c_day && (date_q.day >= month_end(date_q.mon, date_q.yr));
    c_yr  = c_mon && (date_q.mon >= 8'h12);

    tod_n.sec  = c_min ? 8'h00 : bcd_inc(tod_q.sec);
    tod_n.min  = c_min ? (c_hr  ? 8'h00 : bcd_inc(tod_q.min)) : tod_q.min;
    tod_n.hr   = c_hr  ? (c_day ? 8'h00 : bcd_inc(tod_q.hr))  : tod_q.hr;
    date_n.day = c_day ? (c_mon ? 8'h01 : bcd_inc(date_q.day)) : date_q.day;
    date_n.mon = c_mon ? (c_yr  ? 8'h01 : bcd_inc(date_q.mon)) : date_q.mon;
    date_n.yr  = c_yr  ? ((date_q.yr >= 8'h99) ? 8'h00 : bcd_inc(date_q.yr)) : date_q.yr;
    wday_n     = c_day ? ((wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1) : wday_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q     <= '0;
      date_q    <= '{yr: 8'h00, mon: 8'h01, day: 8'h01};
      wday_q    <= 3'd0;
      stepped_o <= 1'b0;
    end else begin
      stepped_o <= adv;
      if (wr_tod_i)  tod_q  <= tod_t'(wdata_i);
      else if (adv)  tod_q  <= tod_n;
      if (wr_date_i) date_q <= date_t'(wdata_i);
      else if (adv)  date_q <= date_n;
      if (wr_wday_i) wday_q <= wdata_i[2:0];
      else if (adv)  wday_q <= wday_n;
    end
  end

  assign tod_o  = tod_q;
  assign date_o = date_q;
  assign wday_o = wday_q;

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> ($stable(tod_q) && $stable(date_q) && $stable(wday_q)));

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_tod_i && tod_q.sec == 8'h59) |=> (tod_q.sec == 8'h00));

  // R6
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_tod_i && !wr_date_i && tod_q == 24'h235959 &&
     date_q.day == month_end(date_q.mon, date_q.yr)) |=> (date_q.day == 8'h01));

endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_atod_i,
  input  logic        wr_adate_i,
  input  logic [23:0] wdata_i,
  input  tod_t        now_tod_i,
  input  date_t       now_date_i,
  output tod_t        atod_o,
  output date_t       adate_o,
  output logic        match_o
);

  tod_t  atod_q;
  date_t adate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      atod_q  <= '0;
      adate_q <= '0;
    end else begin
      if (wr_atod_i)  atod_q  <= tod_t'(wdata_i);
      if (wr_adate_i) adate_q <= date_t'(wdata_i);
    end
  end

  assign match_o = (now_tod_i == atod_q) && (now_date_i == adate_q);
  assign atod_o  = atod_q;
  assign adate_o = adate_q;

endmodule

// File: rtl/bcd_rtc_irq.sv
module bcd_rtc_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            wr_sts_i,
  input  logic [NSRC-1:0] wbits_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] sts_o,
  output logic            irq_o
);

  logic [NSRC-1:0] en_q, sts_q, clr;

  assign clr = wr_sts_i ? wbits_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sts_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wbits_i;
      sts_q <= (sts_q & ~clr) | set_i;
      irq_o <= |(sts_q & en_q);
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sts_i && wbits_i[0] && !set_i[0]) |=> !sts_q[0]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i[1] |=> sts_q[1]);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o);

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int NSRC = 2;

  logic       active_q;
  logic       sel_init, sel_time, sel_cal, sel_wday, sel_atime, sel_acal, sel_ien, sel_sts;
  tod_t       tod, atod;
  date_t      date, adate;
  logic [2:0] wday;
  logic       stepped, match;
  logic [NSRC-1:0] en, sts, set_v;
  logic [31:0] rd_mux;

  assign sel_init  = (bus_addr == ADDR_W'(OFS_INIT));
  assign sel_time  = (bus_addr == ADDR_W'(OFS_TIME));
  assign sel_cal   = (bus_addr == ADDR_W'(OFS_CAL));
  assign sel_wday  = (bus_addr == ADDR_W'(OFS_WDAY));
  assign sel_atime = (bus_addr == ADDR_W'(OFS_ATIME));
  assign sel_acal  = (bus_addr == ADDR_W'(OFS_ACAL));
  assign sel_ien   = (bus_addr == ADDR_W'(OFS_IEN));
  assign sel_sts   = (bus_addr == ADDR_W'(OFS_STS));

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else if (bus_wr && sel_init && bus_wdata == UNLOCK_KEY) active_q <= 1'b1;
  end

  bcd_rtc_counter u_cnt (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active_q),
    .tick_i    (tick_i),
    .wr_tod_i  (bus_wr && active_q && sel_time),
    .wr_date_i (bus_wr && active_q && sel_cal),
    .wr_wday_i (bus_wr && active_q && sel_wday),
    .wdata_i   (bus_wdata[23:0]),
    .tod_o     (tod),
    .date_o    (date),
    .wday_o    (wday),
    .stepped_o (stepped)
  );

  bcd_rtc_alarm u_alm (
    .clk        (clk),
    .rst        (rst),
    .wr_atod_i  (bus_wr && active_q && sel_atime),
    .wr_adate_i (bus_wr && active_q && sel_acal),
    .wdata_i    (bus_wdata[23:0]),
    .now_tod_i  (tod),
    .now_date_i (date),
    .atod_o     (atod),
    .adate_o    (adate),
    .match_o    (match)
  );

  assign set_v = {stepped, stepped && match};

  bcd_rtc_irq #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (bus_wr && sel_ien),
    .wr_sts_i (bus_wr && sel_sts),
    .wbits_i  (bus_wdata[NSRC-1:0]),
    .set_i    (set_v),
    .en_o     (en),
    .sts_o    (sts),
    .irq_o    (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_INIT):  rd_mux = {31'd0, active_q};
      ADDR_W'(OFS_TIME):  rd_mux = {8'd0, tod};
      ADDR_W'(OFS_CAL):   rd_mux = {8'd0, date};
      ADDR_W'(OFS_FMT):   rd_mux = 32'd1;
      ADDR_W'(OFS_WDAY):  rd_mux = {29'd0, wday};
      ADDR_W'(OFS_ATIME): rd_mux = {8'd0, atod};
      ADDR_W'(OFS_ACAL):  rd_mux = {8'd0, adate};
      ADDR_W'(OFS_LEAP):  rd_mux = {31'd0, leap_bcd(date.yr)};
      ADDR_W'(OFS_IEN):   rd_mux = {{(32-NSRC){1'b0}}, en};
      ADDR_W'(OFS_STS):   rd_mux = {{(32-NSRC){1'b0}}, sts};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R2
  active_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |=> active_q);

  // R2
  key_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !(bus_wr && sel_init && bus_wdata == UNLOCK_KEY)) |=> !active_q);

  // R9
  update_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stepped |=> sts[1]);

endmodule

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event  mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    ->mon_ev;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    ->mon_ev;
  endtask

  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(mon_ev);
      while (sb.size() > 0) begin
        it = sb.pop_front();
        act = it.is_irq ? {31'd0, irq} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_rd(6'h00, 32'h0, "R1 init");
    expect_rd(6'h0C, 32'h0, "R1 time");
    expect_rd(6'h10, 32'h000101, "R1 cal");
    expect_rd(6'h18, 32'h0, "R1 wday");
    expect_rd(6'h2C, 32'h0, "R1 status");
    expect_irq(1'b0, "R1 irq");

    // R3 locked behaviour
    wr(6'h0C, 32'h123456);
    wr(6'h1C, 32'h777777);
    tick();
    expect_rd(6'h0C, 32'h0, "R3 time locked");
    expect_rd(6'h2C, 32'h0, "R3 no flag locked");
    wr(6'h00, 32'h12345678);
    expect_rd(6'h00, 32'h0, "R2 wrong key");
    wr(6'h00, 32'hA5EB1357);
    expect_rd(6'h00, 32'h1, "R2 key accepted");
    expect_rd(6'h1C, 32'h0, "R3 alarm write ignored");

    // R13 format
    wr(6'h14, 32'h0);
    expect_rd(6'h14, 32'h1, "R13 fmt");

    // R4 layout, R9/R11 flags
    wr(6'h28, 32'h3);
    wr(6'h0C, 32'h235958);
    wr(6'h10, 32'h991231);
    wr(6'h18, 32'h6);
    expect_rd(6'h0C, 32'h235958, "R4 time readback");
    tick();
    expect_rd(6'h0C, 32'h235959, "R5 sec step");
    expect_rd(6'h2C, 32'h2, "R9 update flag");
    expect_irq(1'b1, "R11 irq update");
    wr(6'h2C, 32'h3);
    expect_rd(6'h2C, 32'h0, "R10 w1c");
    expect_irq(1'b0, "R11 irq cleared");
    tick();
    expect_rd(6'h0C, 32'h000000, "R5 day wrap time");
    expect_rd(6'h10, 32'h000101, "R7 year 99 wrap");
    expect_rd(6'h18, 32'h0, "R6 wday 6 to 0");
    expect_rd(6'h24, 32'h1, "R7 leap 00");

    // R5 minute carry
    wr(6'h0C, 32'h005959);
    tick();
    expect_rd(6'h0C, 32'h010000, "R5 hour carry");

    // R6 month ends
    wr(6'h10, 32'h240228); wr(6'h0C, 32'h235959); tick();
    expect_rd(6'h10, 32'h240229, "R6 leap feb 28");
    expect_rd(6'h18, 32'h1, "R6 wday step");
    wr(6'h0C, 32'h235959); tick();
    expect_rd(6'h10, 32'h240301, "R6 leap feb 29");
    wr(6'h10, 32'h230228); wr(6'h0C, 32'h235959); tick();
    expect_rd(6'h10, 32'h230301, "R6 plain feb");
    expect_rd(6'h24, 32'h0, "R7 leap 23");
    wr(6'h10, 32'h230930); wr(6'h0C, 32'h235959); tick();
    expect_rd(6'h10, 32'h231001, "R6 sep 30");
    wr(6'h10, 32'h231231); wr(6'h0C, 32'h235959); tick();
    expect_rd(6'h10, 32'h240101, "R7 dec wrap");

    // R8 alarm
    wr(6'h28, 32'h1);
    wr(6'h1C, 32'h120005);
    wr(6'h20, 32'h250615);
    wr(6'h10, 32'h250615);
    wr(6'h0C, 32'h120003);
    wr(6'h2C, 32'h3);
    tick();
    expect_rd(6'h2C, 32'h2, "R8 no match yet");
    expect_irq(1'b0, "R11 update masked");
    tick();
    expect_rd(6'h2C, 32'h3, "R8 alarm flag");
    expect_irq(1'b1, "R11 irq alarm");
    expect_rd(6'h1C, 32'h120005, "R4 alarm readback");

    // R12 write with tick
    wr(6'h2C, 32'h3);
    @(negedge clk);
    bus_addr = 6'h0C; bus_wdata = 32'h101010; bus_wr = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_i = 1'b0;
    repeat (2) @(negedge clk);
    expect_rd(6'h0C, 32'h101010, "R12 write wins");
    expect_rd(6'h2C, 32'h2, "R12 tick still counted");

    // R10 set wins over clear
    wr(6'h2C, 32'h3);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    bus_addr = 6'h2C; bus_wdata = 32'h3; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    expect_rd(6'h2C, 32'h2, "R10 set wins");
    wr(6'h2C, 32'h2);
    expect_rd(6'h2C, 32'h0, "R10 later clear");
    expect_rd(6'h0C, 32'h101011, "R5 after collision");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule